// File: doc/BRIEF.md
# Prescaled Modulo Up-Counter Timer

This peripheral holds a 16-bit up-counter. The counter runs between a programmable start value and a programmable limit, then wraps back to the start value. Software reaches it through a flat 32-bit register port that completes every access in a single cycle. Writes take effect on the clock edge that samples them, and reads return data combinationally from the byte offset on the address lines. A power-of-two prescaler sets how many system clocks pass between counter steps. A control field selects whether the counter runs at all.

Each time the counter wraps, a sticky wrap flag is set. When the interrupt enable is also set, a level interrupt stays asserted until software clears the flag. The limit and start values are double-buffered: a write lands in a holding register and is copied into the working register only while the counter is stopped. Software can therefore reprogram the period without corrupting a period that is already in progress. Any write to the count register restarts the count from the working start value.

Top module: `pmtimer`

## Requirements
- R1: After synchronous reset the control word reads 0, the count reads 0, the limit reads 0x0000FFFF, the start value reads 0 and `irq` is low.
- R2: When the clock-select field (control bits 4:3) holds any value other than 1, the count does not change except through a write to the count register.
- R3: With the clock-select field at 1 and the prescale field (control bits 2:0) at P, the count steps once every 2^P clocks. The first step comes 2^P clocks after the clock edge that stored the control write.
- R4: A step taken while the count equals the working limit loads the working start value instead of incrementing, and sets the wrap flag (control bit 7). One full period is limit − start + 1 steps.
- R5: A write of any data to the count register (offset 0x04) loads the count with the working start value on the next edge. This write takes priority over a step in the same cycle.
- R6: Writes to the limit (offset 0x08) and start (offset 0x4C) registers go into holding registers. A holding value is copied into its working register on each clock edge where the clock-select field is 0. Reads of 0x08 and 0x4C return the working values.
- R7: The wrap flag stays set until a control write carries 0 in bit 7. A control write with 1 in bit 7 leaves the flag unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is high exactly when the wrap flag and the interrupt enable (control bit 6) are both set.
- R9: Control bit 5 and bits 31:8, the upper 16 bits of the count, limit and start registers, and every unmapped offset all read as 0.
- R10: The prescale divider restarts whenever the clock-select field is not 1. After the counter is stopped and restarted, a full 2^P clocks pass before the next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: wrap flag AND interrupt enable |

## Verification
A divider that is off by one shows up in the count read-back within 2^P clocks. A wrong limit comparison or reload shows up at the first wrap as a wrong count, together with a flag or `irq` that is missing or set at the wrong time. A working register that copies its holding value while the counter runs changes the 0x08 or 0x4C read-back on the very next clock. Each cycle, the bench reads every register and `irq` and compares them with a behavioural model, so any divergence is caught within one clock of the edge that causes it.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;
    localparam int PS_W   = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_LIMIT = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_START = 7'h4C;

    typedef enum logic [1:0] {
        CS_OFF  = 2'd0,
        CS_MAIN = 2'd1,
        CS_RSV2 = 2'd2,
        CS_RSV3 = 2'd3
    } csel_e;

    // Control word, bits 7:0
    typedef struct packed {
        logic            wrapf;
        logic            ie;
        logic            spare;
        csel_e           csel;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        return {{(DATA_W-8){1'b0}}, c.wrapf, c.ie, 1'b0, c.csel, c.ps};
    endfunction

endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    assign lim  = {DIV_W{1'b1}} >> (DIV_W - int'(ps));
    assign tick = run && (div_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    p_div_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (div_q == '0));

    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && ps != '0) |=> (!tick || ps == '0));

endmodule

// File: rtl/pmt_shadow.sv
module pmt_shadow #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         commit,
    output logic [W-1:0] active
);
    logic [W-1:0] hold_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= RST_VAL;
            act_q  <= RST_VAL;
        end else begin
            if (wr)     hold_q <= wdata;
            if (commit) act_q  <= hold_q;
        end
    end

    assign active = act_q;

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(act_q));

    p_commit_r6: assert property (@(posedge clk) disable iff (rst)
        commit |=> (act_q == $past(hold_q)));

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] start,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_q;
    logic         at_lim;

    assign at_lim = (cnt_q == limit);
    assign wrap   = tick && at_lim;
    assign cnt    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= start;
        else if (tick) cnt_q <= at_lim ? start : cnt_q + W'(1);
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && !at_lim) |=> (cnt_q == $past(cnt_q) + W'(1)));

    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && at_lim) |=> (cnt_q == $past(start)));

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(start)));

endmodule

// File: rtl/pmtimer.sv
module pmtimer
    import pmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int PAD_W = DATA_W - CNT_W;
    localparam int N_SH  = 2;   // 0: limit, 1: start

    ctrl_t            ctrl_q;
    logic             wr_ctrl, wr_count;
    logic [N_SH-1:0]  sh_wr;
    logic [CNT_W-1:0] sh_act [N_SH];
    logic             run, commit, tick, wrap;
    logic [CNT_W-1:0] cnt;
    logic             unused_bits;

    assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
    assign wr_count = bus_we && (bus_addr == OFS_COUNT);
    assign sh_wr[0] = bus_we && (bus_addr == OFS_LIMIT);
    assign sh_wr[1] = bus_we && (bus_addr == OFS_START);
    assign run      = (ctrl_q.csel == CS_MAIN);
    assign commit   = (ctrl_q.csel == CS_OFF);
    assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_W], bus_wdata[5]};

    for (genvar g = 0; g < N_SH; g++) begin : g_shadow
        pmt_shadow #(
            .W       (CNT_W),
            .RST_VAL ((g == 0) ? {CNT_W{1'b1}} : {CNT_W{1'b0}})
        ) u_sh (
            .clk    (clk),
            .rst    (rst),
            .wr     (sh_wr[g]),
            .wdata  (bus_wdata[CNT_W-1:0]),
            .commit (commit),
            .active (sh_act[g])
        );
    end

    pmt_prescaler #(.PS_W(PS_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .ps   (ctrl_q.ps),
        .tick (tick)
    );

    pmt_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .load  (wr_count),
        .limit (sh_act[0]),
        .start (sh_act[1]),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.ps    <= bus_wdata[PS_W-1:0];
            ctrl_q.csel  <= csel_e'(bus_wdata[4:3]);
            ctrl_q.ie    <= bus_wdata[6];
            ctrl_q.wrapf <= (ctrl_q.wrapf & bus_wdata[7]) | wrap;
        end else if (wrap) begin
            ctrl_q.wrapf <= 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = ctrl_word(ctrl_q);
            OFS_COUNT: bus_rdata = {{PAD_W{1'b0}}, cnt};
            OFS_LIMIT: bus_rdata = {{PAD_W{1'b0}}, sh_act[0]};
            OFS_START: bus_rdata = {{PAD_W{1'b0}}, sh_act[1]};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = ctrl_q.wrapf & ctrl_q.ie;

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && ctrl_q == '0 && sh_act[0] == '1
                        && sh_act[1] == '0 && !irq));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.wrapf && !wr_ctrl) |=> ctrl_q.wrapf);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_ctrl) |=> irq);

endmodule

// File: tb/pmtimer_tb_top.sv
module pmtimer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  addr = '0;
    logic [31:0] wd = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    bit          done = 1'b0;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";

    int m_cnt, m_mod, m_ini, m_bmod, m_bini, m_ps, m_cs, m_ie, m_ovf, m_div;

    always #5 clk = ~clk;

    pmtimer dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_wdata (wd),
        .bus_we    (we),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    // Behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin : model
        int  ncnt, old_cs, nmod, nini;
        bit  run, tk, wrp;
        if (rst) begin
            m_cnt = 0; m_mod = 65535; m_ini = 0; m_bmod = 65535; m_bini = 0;
            m_ps = 0; m_cs = 0; m_ie = 0; m_ovf = 0; m_div = 0;
        end else begin
            run    = (m_cs == 1);
            tk     = run && (m_div == (1 << m_ps) - 1);
            wrp    = tk && (m_cnt == m_mod);
            old_cs = m_cs;
            ncnt   = m_cnt;
            if (we && addr == 7'h04) ncnt = m_ini;
            else if (tk)             ncnt = wrp ? m_ini : (m_cnt + 1) % 65536;
            m_div = (!run || tk) ? 0 : m_div + 1;
            if (we && addr == 7'h00) begin
                m_ovf = ((m_ovf != 0) && wd[7]) || wrp;
                m_ps  = int'(wd[2:0]);
                m_cs  = int'(wd[4:3]);
                m_ie  = int'(wd[6]);
            end else if (wrp) begin
                m_ovf = 1;
            end
            nmod = m_mod; nini = m_ini;
            if (old_cs == 0) begin nmod = m_bmod; nini = m_bini; end
            if (we && addr == 7'h08) m_bmod = int'(wd[15:0]);
            if (we && addr == 7'h4C) m_bini = int'(wd[15:0]);
            m_mod = nmod; m_ini = nini; m_cnt = ncnt;
        end
    end

    function automatic logic [31:0] expect_rd(input logic [6:0] a);
        case (a)
            7'h00:   return 32'((m_ovf << 7) | (m_ie << 6) | (m_cs << 3) | m_ps);
            7'h04:   return 32'(m_cnt);
            7'h08:   return 32'(m_mod);
            7'h4C:   return 32'(m_ini);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, got, exp);
        end
    endtask

    // Wait for the edge, then compare every register and irq
    task automatic cyc();
        @(posedge clk);
        #1;
        we = 1'b0;
        addr = 7'h00; #1; chk("R9 control", rdata, expect_rd(7'h00));
        addr = 7'h04; #1; chk({phase, " count"}, rdata, expect_rd(7'h04));
        addr = 7'h08; #1; chk("R6 limit", rdata, expect_rd(7'h08));
        addr = 7'h4C; #1; chk("R6 start", rdata, expect_rd(7'h4C));
        addr = 7'h10; #1; chk("R9 unmapped", rdata, 32'h0);
        chk("R8 irq", {31'b0, irq}, {31'b0, (m_ovf != 0) && (m_ie != 0)});
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        addr = a; wd = d; we = 1'b1;
        cyc();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        phase = "R1";
        repeat (2) cyc();

        phase = "R6";
        wr(7'h08, 32'h0000_0005);
        wr(7'h4C, 32'hABCD_0002);
        repeat (2) cyc();

        phase = "R5";
        wr(7'h04, 32'hDEAD_BEEF);
        cyc();

        phase = "R4";
        wr(7'h00, 32'h08);
        repeat (12) cyc();

        phase = "R8";
        wr(7'h00, 32'hC8);
        repeat (3) cyc();

        phase = "R7";
        wr(7'h00, 32'h48);
        cyc();
        wr(7'h00, 32'hC8);
        repeat (2) cyc();

        phase = "R6";
        wr(7'h08, 32'h0000_0009);
        repeat (8) cyc();
        wr(7'h00, 32'h00);
        repeat (2) cyc();

        phase = "R3";
        wr(7'h04, 32'h0);
        wr(7'h00, 32'h0A);
        repeat (40) cyc();
        wr(7'h00, 32'h0F);
        repeat (300) cyc();

        phase = "R2";
        wr(7'h00, 32'h10);
        repeat (10) cyc();
        wr(7'h00, 32'h18);
        repeat (5) cyc();

        phase = "R10";
        wr(7'h00, 32'h0B);
        repeat (5) cyc();
        wr(7'h00, 32'h03);
        cyc();
        wr(7'h00, 32'h0B);
        repeat (20) cyc();

        phase = "R9";
        wr(7'h00, 32'hFFFF_FF20);
        wr(7'h10, 32'h0000_0005);
        wr(7'h08, 32'h1234_0003);
        repeat (3) cyc();

        phase = "R5";
        wr(7'h00, 32'h08);
        repeat (6) cyc();
        wr(7'h04, 32'h0);
        repeat (4) cyc();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule